// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block recognises whether an I2C transfer is addressed to this slave and decides how the acknowledge slot is answered. A bit-level front end supplies it with START and STOP strobes and with each received byte as a one-cycle strobe plus data, issued just before the acknowledge slot. The unit compares the first byte after a START against a programmed 7-bit address, or the two header bytes of a 10-bit address. When enabled, it also accepts the general call address (0x00) and the START byte (0x01).

For each byte that it answers, the unit either produces an acknowledge decision one cycle later or, in interactive mode, raises a receive interrupt and requests that SCL be held low. It keeps that request until software writes the control strobe with its ACK/NACK choice. A status output reports whether the transfer is addressed to this slave, whether the match was on the general call or START byte, and the direction bit.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, ack_vld, ack_nak, scl_hold, rx_irq, st_sel, st_gca and st_rd are 0, and a byte received before any START gets no response.
- R2: With cfg_mode = 2'b10 (slave only, 7-bit), a first byte after START whose bits [7:1] equal cfg_sla[6:0] gives ack_vld = 1 in the next cycle with ack_nak = cfg_nak. In that same cycle st_sel = 1, st_gca = 0 and st_rd = byte bit 0.
- R3: In 7-bit mode, cfg_sla[9:8] has no effect on matching.
- R4: A first byte that matches nothing gives no ack_vld, no rx_irq and no scl_hold, for that byte and for every later byte up to the next START.
- R5: Byte 0x00 as the first byte is accepted only when cfg_gce = 1. It is then acknowledged with st_gca = 1 and st_rd = 0. With cfg_gce = 0 it gets no response.
- R6: Byte 0x01 as the first byte, with cfg_gce = 1, gives ack_vld with ack_nak = 1 regardless of cfg_nak or cfg_irm, and reports st_gca = 1 and st_rd = 1. Later bytes up to the next START get no response.
- R7: With cfg_mode = 2'b01 or 2'b11 (10-bit), the first byte {5'b11110, cfg_sla[9:8], 1'b0} is acknowledged with st_sel = 0. A following byte equal to cfg_sla[7:0] is acknowledged with st_sel = 1 and st_rd = 0. Any other second byte gets no response.
- R8: After a completed 10-bit write match, a repeated START followed by {5'b11110, cfg_sla[9:8], 1'b1} is acknowledged with st_sel = 1 and st_rd = 1. The same byte without such a prior match gets no response.
- R9: With cfg_irm = 1, each answered byte gives a one-cycle rx_irq and sets scl_hold in the next cycle, with no ack_vld. A ctl_wr while scl_hold = 1 gives, in the next cycle, ack_vld = 1, ack_nak = ctl_nak and scl_hold = 0.
- R10: Data bytes in a selected write transfer are answered with ack_nak = cfg_nak. Data bytes in a selected read transfer get no response.
- R11: A START or STOP clears scl_hold in the next cycle. When it coincides with ctl_wr, no ack_vld is produced.
- R12: With cfg_mode = 2'b00, no byte is recognised, including 0x00 and 0x01.
- R13: A ctl_wr while scl_hold = 0 produces no ack_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Addressing mode: 00 off, 01 master/slave 10-bit, 10 slave 7-bit, 11 slave 10-bit |
| cfg_sla | input | 10 | Own slave address |
| cfg_gce | input | 1 | Accept general call address and START byte |
| cfg_irm | input | 1 | Interactive receive mode |
| cfg_nak | input | 1 | Level for automatic acknowledge (1 = NACK) |
| start_det | input | 1 | START or repeated START strobe |
| stop_det | input | 1 | STOP strobe |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| ctl_wr | input | 1 | Software control write strobe |
| ctl_nak | input | 1 | NAK value carried by the control write |
| ack_vld | output | 1 | Acknowledge decision pulse |
| ack_nak | output | 1 | SDA level for the acknowledge slot (1 = NACK) |
| scl_hold | output | 1 | Request to hold SCL low |
| rx_irq | output | 1 | Receive interrupt pulse |
| st_sel | output | 1 | Transfer is addressed to this slave |
| st_gca | output | 1 | Match was on general call or START byte |
| st_rd | output | 1 | Direction bit of the match |

## Verification
The software release of a stretched acknowledge can land in the same cycle as a START or STOP that ends the transfer. The bench parks the unit in interactive mode with SCL held, then raises ctl_wr together with start_det, and separately raises stop_det alone. It requires that scl_hold drops in the next cycle and that no acknowledge decision leaks out. The next address is then checked to be decoded afresh.

// File: rtl/i2csam_pkg.sv
package i2csam_pkg;
  localparam int BYTE_W = 8;
  localparam int SLA_W  = 10;
  localparam int MODE_W = 2;
  localparam int HDR_W  = 5;

  localparam logic [BYTE_W-1:0] GC_BYTE    = 8'h00;
  localparam logic [BYTE_W-1:0] SB_BYTE    = 8'h01;
  localparam logic [HDR_W-1:0]  TEN_PREFIX = 5'b11110;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 2'b00,
    MODE_MS10 = 2'b01,
    MODE_SO7  = 2'b10,
    MODE_SO10 = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_DATA, ST_SKIP
  } st_e;

  typedef enum logic [2:0] {
    CL_NONE, CL_GC, CL_SB, CL_OWN7, CL_HDRW, CL_HDRR
  } cls_e;
endpackage

// File: rtl/i2csam_rst.sv
module i2csam_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/i2csam_classify.sv
module i2csam_classify
  import i2csam_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        sla_hi,
  input  logic [6:0]        sla_lo7,
  input  logic              gce,
  input  logic              ten_done,
  input  logic [BYTE_W-1:0] data,
  output cls_e              cls
);
  logic ten_mode;

  always_comb begin
    ten_mode = (mode == MODE_MS10) || (mode == MODE_SO10);
    cls      = CL_NONE;
    if (mode == MODE_OFF) begin
      cls = CL_NONE;
    end else if (data == GC_BYTE) begin
      cls = gce ? CL_GC : CL_NONE;
    end else if (data == SB_BYTE) begin
      cls = gce ? CL_SB : CL_NONE;
    end else if (ten_mode) begin
      if (data[7:3] == TEN_PREFIX && data[2:1] == sla_hi) begin
        if (!data[0])     cls = CL_HDRW;
        else if (ten_done) cls = CL_HDRR;
      end
    end else if (data[7:1] == sla_lo7) begin
      cls = CL_OWN7;
    end
  end
endmodule

// File: rtl/i2csam_ack.sv
module i2csam_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic force_nak,
  input  logic abort,
  input  logic irm,
  input  logic auto_nak,
  input  logic ctl_wr,
  input  logic ctl_nak,
  output logic ack_vld,
  output logic ack_nak,
  output logic hold,
  output logic irq
);
  logic vld_q, nak_q, hold_q, irq_q;
  logic vld_n, nak_n, hold_n, irq_n;

  always_comb begin
    vld_n  = 1'b0;
    irq_n  = 1'b0;
    nak_n  = nak_q;
    hold_n = hold_q;
    if (abort) begin
      hold_n = 1'b0;
    end else if (req) begin
      if (irm && !force_nak) begin
        irq_n  = 1'b1;
        hold_n = 1'b1;
      end else begin
        vld_n  = 1'b1;
        nak_n  = force_nak | auto_nak;
        hold_n = 1'b0;
      end
    end else if (ctl_wr && hold_q) begin
      vld_n  = 1'b1;
      nak_n  = ctl_nak;
      hold_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      nak_q  <= 1'b0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      nak_q  <= nak_n;
      hold_q <= hold_n;
      irq_q  <= irq_n;
    end
  end

  assign ack_vld = vld_q;
  assign ack_nak = nak_q;
  assign hold    = hold_q;
  assign irq     = irq_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2csam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [SLA_W-1:0]  cfg_sla,
  input  logic              cfg_gce,
  input  logic              cfg_irm,
  input  logic              cfg_nak,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              ctl_wr,
  input  logic              ctl_nak,
  output logic              ack_vld,
  output logic              ack_nak,
  output logic              scl_hold,
  output logic              rx_irq,
  output logic              st_sel,
  output logic              st_gca,
  output logic              st_rd
);
  logic rst_i_n;
  st_e  st_q, st_n;
  logic sel_q, sel_n, gca_q, gca_n, rd_q, rd_n, tdone_q, tdone_n;
  logic req, fnak;
  cls_e cls;

  i2csam_rst u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  i2csam_classify u_cls (
    .mode(cfg_mode), .sla_hi(cfg_sla[9:8]), .sla_lo7(cfg_sla[6:0]),
    .gce(cfg_gce), .ten_done(tdone_q), .data(byte_data), .cls(cls)
  );

  always_comb begin
    st_n    = st_q;
    sel_n   = sel_q;
    gca_n   = gca_q;
    rd_n    = rd_q;
    tdone_n = tdone_q;
    req     = 1'b0;
    fnak    = 1'b0;
    if (stop_det) begin
      st_n    = ST_IDLE;
      sel_n   = 1'b0;
      tdone_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADR1;
      sel_n = 1'b0;
      gca_n = 1'b0;
      rd_n  = 1'b0;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_ADR1: begin
          tdone_n = 1'b0;
          st_n    = ST_SKIP;
          unique case (cls)
            CL_GC:   begin st_n = ST_DATA; sel_n = 1'b1; gca_n = 1'b1; rd_n = 1'b0; req = 1'b1; end
            CL_SB:   begin gca_n = 1'b1; rd_n = 1'b1; req = 1'b1; fnak = 1'b1; end
            CL_OWN7: begin st_n = ST_DATA; sel_n = 1'b1; gca_n = 1'b0; rd_n = byte_data[0]; req = 1'b1; end
            CL_HDRW: begin st_n = ST_ADR2; gca_n = 1'b0; rd_n = 1'b0; req = 1'b1; end
            CL_HDRR: begin st_n = ST_DATA; sel_n = 1'b1; gca_n = 1'b0; rd_n = 1'b1; req = 1'b1; tdone_n = 1'b1; end
            default: ;
          endcase
        end
        ST_ADR2: begin
          if (byte_data == cfg_sla[7:0]) begin
            st_n    = ST_DATA;
            sel_n   = 1'b1;
            rd_n    = 1'b0;
            tdone_n = 1'b1;
            req     = 1'b1;
          end else begin
            st_n = ST_SKIP;
          end
        end
        ST_DATA: req = !rd_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      sel_q   <= 1'b0;
      gca_q   <= 1'b0;
      rd_q    <= 1'b0;
      tdone_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      sel_q   <= sel_n;
      gca_q   <= gca_n;
      rd_q    <= rd_n;
      tdone_q <= tdone_n;
    end
  end

  i2csam_ack u_ack (
    .clk(clk), .rst_n(rst_i_n), .req(req), .force_nak(fnak),
    .abort(start_det | stop_det), .irm(cfg_irm), .auto_nak(cfg_nak),
    .ctl_wr(ctl_wr), .ctl_nak(ctl_nak),
    .ack_vld(ack_vld), .ack_nak(ack_nak), .hold(scl_hold), .irq(rx_irq)
  );

  assign st_sel = sel_q;
  assign st_gca = gca_q;
  assign st_rd  = rd_q;
endmodule

// File: rtl/i2csam_chk.sv
module i2csam_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       start_det,
  input logic       stop_det,
  input logic       byte_vld,
  input logic       ctl_wr,
  input logic       ctl_nak,
  input logic       ack_vld,
  input logic       ack_nak,
  input logic       scl_hold,
  input logic       rx_irq,
  input logic       st_gca,
  input logic       st_rd
);
  // R9: an interrupt always comes with a stretch request
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> scl_hold);

  // R9: a decision is never given while SCL is still held
  p_ack_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> !scl_hold);

  // R9: software release yields the written decision one cycle later
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && scl_hold && !start_det && !stop_det && !byte_vld)
    |=> (ack_vld && !scl_hold && ack_nak == $past(ctl_nak)));

  // R11: START/STOP drops the stretch and suppresses any decision
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!scl_hold && !ack_vld));

  // R6: the START byte is never acknowledged
  p_sbyte_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && st_gca && st_rd) |-> ack_nak);

  // R12: disabled mode answers nothing
  p_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && cfg_mode == 2'b00 && !ctl_wr) |=> (!ack_vld && !rx_irq));
endmodule

bind i2c_addr_match i2csam_chk u_chk (.*);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [9:0] cfg_sla;
  logic       cfg_gce, cfg_irm, cfg_nak;
  logic       start_det, stop_det, byte_vld, ctl_wr, ctl_nak;
  logic [7:0] byte_data;
  logic       ack_vld, ack_nak, scl_hold, rx_irq, st_sel, st_gca, st_rd;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match i_i2c_addr_match (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_vld = 1'b1; byte_data = b; end
    @(negedge clk) byte_vld = 1'b0;
  endtask

  task automatic sw_write(input logic n);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_nak = n; end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  // {answered, forced nak, gca, rd} for a first byte in 7-bit mode
  function automatic logic [3:0] exp7(input logic [6:0] a, input logic g,
                                      input logic [7:0] b);
    if (b == 8'h00)      return g ? 4'b1010 : 4'b0000;
    if (b == 8'h01)      return g ? 4'b1111 : 4'b0000;
    if (b[7:1] == a)     return {3'b100, b[0]};
    return 4'b0000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] e;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cfg_mode = 2'b10; cfg_sla = 10'h3A5; cfg_gce = 1'b0; cfg_irm = 1'b0; cfg_nak = 1'b0;
    start_det = 1'b0; stop_det = 1'b0; byte_vld = 1'b0; ctl_wr = 1'b0; ctl_nak = 1'b0;
    byte_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state and no response before a START
    check("R1 reset outputs", {ack_vld, ack_nak, scl_hold, rx_irq, st_sel, st_gca, st_rd}, 0);
    send(8'h4A);
    check("R1 byte before start", ack_vld, 0);

    // R2/R3: 7-bit write match, sla[9:8]=11 irrelevant
    do_start(); send(8'h4A);
    check("R2 ack_vld", ack_vld, 1);
    check("R2 ack_nak", ack_nak, 0);
    check("R2 st_sel", st_sel, 1);
    check("R2 st_rd", st_rd, 0);
    check("R3 upper bits ignored", st_gca, 0);
    // R10 data bytes in write
    send(8'h5A);
    check("R10 data ack", ack_vld, 1);
    cfg_nak = 1'b1; send(8'h33);
    check("R10 data nak level", ack_nak, 1);
    cfg_nak = 1'b0; do_stop();

    // R2 read; R10 no answer on read data
    do_start(); send(8'h4B);
    check("R2 read ack", ack_vld, 1);
    check("R2 read st_rd", st_rd, 1);
    send(8'hC3);
    check("R10 read data no answer", ack_vld, 0);
    do_stop();

    // R4 mismatch
    do_start(); send(8'h40);
    check("R4 mismatch no ack", ack_vld, 0);
    send(8'h4A);
    check("R4 later byte no ack", ack_vld, 0);
    check("R4 no irq/hold", {rx_irq, scl_hold}, 0);
    do_stop();

    // R5 general call
    do_start(); send(8'h00);
    check("R5 gc disabled", ack_vld, 0);
    do_stop();
    cfg_gce = 1'b1;
    do_start(); send(8'h00);
    check("R5 gc ack", ack_vld, 1);
    check("R5 gc status", {st_gca, st_rd}, 2);
    do_stop();

    // R6 START byte, even with irm on
    cfg_irm = 1'b1;
    do_start(); send(8'h01);
    check("R6 start byte answered", ack_vld, 1);
    check("R6 start byte nak", ack_nak, 1);
    check("R6 start byte status", {st_gca, st_rd}, 3);
    check("R6 no irq", rx_irq, 0);
    send(8'h00);
    check("R6 later byte ignored", ack_vld, 0);
    do_stop();
    cfg_irm = 1'b0;

    // R7/R8 10-bit
    cfg_mode = 2'b11; cfg_sla = 10'h2C7;
    do_start(); send(8'hF4);
    check("R7 header ack", ack_vld, 1);
    check("R7 header not selected", st_sel, 0);
    send(8'hC7);
    check("R7 second byte ack", ack_vld, 1);
    check("R7 selected write", {st_sel, st_rd}, 2);
    do_start(); send(8'hF5);
    check("R8 repeated start read", ack_vld, 1);
    check("R8 read selected", {st_sel, st_rd}, 3);
    do_stop();
    do_start(); send(8'hF5);
    check("R8 read without write", ack_vld, 0);
    do_stop();
    cfg_mode = 2'b01;
    do_start(); send(8'hF4); send(8'h11);
    check("R7 wrong second byte", ack_vld, 0);
    do_stop();

    // R9 interactive mode
    cfg_mode = 2'b10; cfg_sla = 10'h025; cfg_irm = 1'b1;
    do_start(); send(8'h4A);
    check("R9 irq", rx_irq, 1);
    check("R9 hold", scl_hold, 1);
    check("R9 no ack yet", ack_vld, 0);
    repeat (3) @(negedge clk);
    check("R9 hold kept", {scl_hold, ack_vld, rx_irq}, 4);
    sw_write(1'b1);
    check("R9 release ack", {ack_vld, ack_nak, scl_hold}, 6);
    send(8'h77);
    check("R9 data irq", {rx_irq, scl_hold}, 3);
    sw_write(1'b0);
    check("R9 data release", {ack_vld, ack_nak, scl_hold}, 4);
    // R13 stray write
    sw_write(1'b1);
    check("R13 stray ctl_wr", ack_vld, 0);

    // R11 collision: ctl_wr with start
    send(8'h12);
    check("R11 setup hold", scl_hold, 1);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_nak = 1'b0; start_det = 1'b1; end
    @(negedge clk) begin ctl_wr = 1'b0; start_det = 1'b0; end
    check("R11 start beats ctl_wr", {ack_vld, scl_hold}, 0);
    cfg_irm = 1'b0;
    send(8'h4A);
    check("R11 fresh address after start", ack_vld, 1);
    cfg_irm = 1'b1;
    send(8'h20);
    check("R11 setup hold 2", scl_hold, 1);
    do_stop();
    check("R11 stop releases", {ack_vld, scl_hold}, 0);
    cfg_irm = 1'b0;

    // R12 disabled mode
    cfg_mode = 2'b00;
    do_start(); send(8'h00);
    check("R12 off gc", ack_vld, 0);
    do_start(); send(8'h4A);
    check("R12 off own", ack_vld, 0);
    do_stop();

    // Random 7-bit traffic
    cfg_mode = 2'b10;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      cfg_sla = 10'($urandom);
      cfg_gce = 1'($urandom);
      cfg_nak = 1'($urandom);
      b = ($urandom % 3 == 0) ? {cfg_sla[6:0], 1'($urandom)} : 8'($urandom % 4 == 0 ? $urandom % 2 : $urandom);
      e = exp7(cfg_sla[6:0], cfg_gce, b);
      do_start(); send(b);
      check("R2 random answer", ack_vld, e[3]);
      if (e[3]) check("R5 random level", ack_nak, e[2] | cfg_nak);
      check("R6 random status", {st_gca, st_rd}, e[1:0]);
      do_stop();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule